// File: doc/BRIEF.md
# Dual-Counter Event Monitor

The block keeps two 32-bit event counters for a processor core, packed side by side in one 64-bit counter register, and one shared control register that picks the event each counter follows and which privilege levels may count. Every clock the core presents a set of event strobes and the privilege level of the current cycle. A counter advances by one when its chosen strobe is high and the enable bit for the present privilege level is set.

Both counters share the same privilege enables, so one counter cannot be halted while the other runs. A counter that software does not need is instead steered to a marker event that almost never fires. When a counter wraps past its all-ones value, a per-counter overflow flag is set. This lets software tell which counter wrapped, including one it was not using. An interrupt line reports any set flag while interrupts are enabled. Software sets a sampling period by preloading a counter with the two's complement of that period.

Top module: `evmon_top`

## Requirements
- R1: After reset the control register reads 0x0000_0000_0000_E140, meaning both counters are parked and every enable is off. The counter register reads 0, the status register reads 0 and `ovf_irq` is low.
- R2: Address 1 is the counter register. The upper counter sits in bits 63:32 and the lower counter in bits 31:0. A write replaces both halves in the clock that follows.
- R3: If a counter-register write and a counted event occur in the same cycle, the written value is stored and no overflow is flagged for that cycle.
- R4: Address 0 is the control register. Bit 0 enables the interrupt. Bits 1, 2 and 3 enable counting at user, supervisor and hypervisor level. Bits 9:4 select the lower counter's event and bits 16:11 select the upper counter's event. Bit 10 and bits 63:17 always read 0. Address 3 reads 0 and ignores writes.
- R5: Event code 0x00 counts `ev_cycle` and code 0x01 counts `ev_instr` on either counter. Code 0x09 counts `ev_cache_ref` on the lower counter and `ev_cache_miss` on the upper counter. Any other unparked code never counts.
- R6: `priv_lvl` is 0 for user, 1 for supervisor, 2 for hypervisor and 3 for no context. A counter advances only when the enable bit for the current level is set, and level 3 never counts.
- R7: Parking code 0x14 on the lower counter and 0x1C on the upper counter counts only `ev_marker_nop`.
- R8: A counter changes by at most one per clock unless it is written.
- R9: When a counter advances from 0xFFFF_FFFF it becomes 0 and sets its overflow flag. The flags are read at address 2, with bit 0 for the lower counter and bit 1 for the upper counter.
- R10: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged. If a wrap and a clear happen in the same cycle, the flag stays set.
- R11: `ovf_irq` is high exactly when control bit 0 is set and at least one overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 counters, 2 status) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| priv_lvl | input | 2 | Privilege level of the current cycle |
| ev_cycle | input | 1 | Cycle strobe |
| ev_instr | input | 1 | Retired-instruction strobe |
| ev_cache_ref | input | 1 | Cache reference strobe |
| ev_cache_miss | input | 1 | Cache miss strobe |
| ev_marker_nop | input | 1 | Marker-NOP strobe that parked counters count |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
Every register, counter and flag changes at the first rising edge after its stimulus. The read port is combinational, so a result appears on `reg_rdata` during the next cycle. `ovf_irq` also follows the flags in that cycle, with no further delay. The bench applies inputs at the falling edge and compares `reg_rdata` and `ovf_irq` against its model just before the next rising edge. At that point the model holds the state left by all earlier edges. The model is advanced only after that rising edge, so every comparison lines up with the state the design holds in that cycle.

// File: rtl/evmon_pkg.sv
// Shared encodings and default geometry for the dual-counter event monitor.
package evmon_pkg;
    localparam int EVM_CNT_W   = 32;
    localparam int EVM_SEL_W   = 6;
    localparam int EVM_LO_LSB  = 4;
    localparam int EVM_UP_LSB  = 11;
    localparam int EVM_PARK_LO = 8'h14;
    localparam int EVM_PARK_UP = 8'h1C;

    // Event codes decoded by the selectors
    localparam int EVC_CYCLE = 0;
    localparam int EVC_INSTR = 1;
    localparam int EVC_CACHE = 9;

    // Control register bit positions
    localparam int CB_IRQ_EN = 0;
    localparam int CB_USER   = 1;
    localparam int CB_SUPER  = 2;
    localparam int CB_HYPER  = 3;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_CNT  = 2'd1,
        ADR_STAT = 2'd2,
        ADR_NONE = 2'd3
    } evm_addr_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_HYPER = 2'd2,
        PRV_IDLE  = 2'd3
    } evm_priv_e;
endpackage

// File: rtl/evmon_ctrl.sv
// Control register: interrupt enable, three shared context enables and two
// event-select fields. Assumes the caller decodes the address and presents
// only the write-data slices that map to real fields.
module evmon_ctrl #(
    parameter int SEL_W   = 6,
    parameter int PARK_LO = 8'h14,
    parameter int PARK_UP = 8'h1C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [3:0]       wr_flags,
    input  logic [SEL_W-1:0] wr_sel_lo,
    input  logic [SEL_W-1:0] wr_sel_up,
    output logic             irq_en,
    output logic [2:0]       ctx_en,
    output logic [SEL_W-1:0] sel_lo,
    output logic [SEL_W-1:0] sel_up
);
    // Store fields; reset parks both counters with every enable off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            ctx_en <= '0;
            sel_lo <= SEL_W'(PARK_LO);
            sel_up <= SEL_W'(PARK_UP);
        end else if (we) begin
            irq_en <= wr_flags[0];
            ctx_en <= wr_flags[3:1];
            sel_lo <= wr_sel_lo;
            sel_up <= wr_sel_up;
        end
    end
endmodule

// File: rtl/evmon_counter.sv
// One event counter with its own event selector. IS_UPPER picks which cache
// strobe code 0x09 maps to and which park code applies. Assumes ctx_ok is
// already the privilege gate for this cycle. A write overrides an increment.
module evmon_counter #(
    parameter int CNT_W     = 32,
    parameter int SEL_W     = 6,
    parameter bit IS_UPPER  = 1'b0,
    parameter int PARK_CODE = 8'h14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             ctx_ok,
    input  logic             ev_cycle,
    input  logic             ev_instr,
    input  logic             ev_cache_ref,
    input  logic             ev_cache_miss,
    input  logic             ev_marker_nop,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    import evmon_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic ev_sel;
    logic inc;

    // Select the strobe named by the event code
    always_comb begin
        if (sel == SEL_W'(EVC_CYCLE))      ev_sel = ev_cycle;
        else if (sel == SEL_W'(EVC_INSTR)) ev_sel = ev_instr;
        else if (sel == SEL_W'(EVC_CACHE)) ev_sel = IS_UPPER ? ev_cache_miss : ev_cache_ref;
        else if (sel == SEL_W'(PARK_CODE)) ev_sel = ev_marker_nop;
        else                               ev_sel = 1'b0;
    end

    assign inc  = ev_sel & ctx_ok;
    assign wrap = inc & ~wr_en & (cnt_q == CNT_MAX);

    // Counter register: write wins, else step by one on a gated event
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_en)  cnt_q <= wr_val;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    // R8: never more than one step per clock without a write
    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R6: a closed privilege gate freezes the count
    a_r6_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_ok && !wr_en) |=> $stable(cnt_q));

    // R3: a write lands regardless of events
    a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt_q == $past(wr_val));
endmodule

// File: rtl/evmon_irq.sv
// Sticky overflow flags with write-one-to-clear and the interrupt line.
// Assumes set pulses last one cycle; a set beats a clear in the same cycle.
module evmon_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic         irq_en,
    output logic [N-1:0] flags_q,
    output logic         irq_o
);
    // Update flags: clear requested bits, then OR in new wraps
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~(clr_we ? clr_mask : '0)) | set_i;
    end

    // Interrupt when enabled and any flag is pending
    assign irq_o = irq_en & (|flags_q);

    // R9: a flag only rises after a wrap pulse
    a_r9_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((flags_q & ~$past(flags_q)) == '0));

    // R10: a flag persists unless cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/evmon_top.sv
// Dual-counter event monitor: control register, two gated event counters in
// one 64-bit register, sticky overflow flags and interrupt. Assumes one
// register access per cycle; reads are combinational on reg_addr.
module evmon_top
    import evmon_pkg::*;
#(
    parameter int CNT_W   = EVM_CNT_W,
    parameter int SEL_W   = EVM_SEL_W,
    parameter int LO_LSB  = EVM_LO_LSB,
    parameter int UP_LSB  = EVM_UP_LSB,
    parameter int PARK_LO = EVM_PARK_LO,
    parameter int PARK_UP = EVM_PARK_UP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [2*CNT_W-1:0] reg_wdata,
    output logic [2*CNT_W-1:0] reg_rdata,
    input  logic [1:0]         priv_lvl,
    input  logic               ev_cycle,
    input  logic               ev_instr,
    input  logic               ev_cache_ref,
    input  logic               ev_cache_miss,
    input  logic               ev_marker_nop,
    output logic               ovf_irq
);
    localparam int DATA_W = 2 * CNT_W;
    localparam int CTRL_W = UP_LSB + SEL_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             ctrl_we, cnt_we, stat_we;
    logic             irq_en;
    logic [2:0]       ctx_en;
    logic [SEL_W-1:0] sel_lo, sel_up;
    logic             ctx_ok;
    logic [CNT_W-1:0] cnt_val [2];
    logic [1:0]       wrap;
    logic [1:0]       flags;
    logic [CTRL_W-1:0] ctrl_word;

    // Decode register writes
    assign ctrl_we = reg_we && (reg_addr == ADR_CTRL);
    assign cnt_we  = reg_we && (reg_addr == ADR_CNT);
    assign stat_we = reg_we && (reg_addr == ADR_STAT);

    evmon_ctrl #(.SEL_W(SEL_W), .PARK_LO(PARK_LO), .PARK_UP(PARK_UP)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wr_flags (reg_wdata[3:0]),
        .wr_sel_lo(reg_wdata[LO_LSB +: SEL_W]),
        .wr_sel_up(reg_wdata[UP_LSB +: SEL_W]),
        .irq_en   (irq_en),
        .ctx_en   (ctx_en),
        .sel_lo   (sel_lo),
        .sel_up   (sel_up)
    );

    // Shared privilege gate for both counters
    always_comb begin
        case (priv_lvl)
            PRV_USER:  ctx_ok = ctx_en[CB_USER-1];
            PRV_SUPER: ctx_ok = ctx_en[CB_SUPER-1];
            PRV_HYPER: ctx_ok = ctx_en[CB_HYPER-1];
            default:   ctx_ok = 1'b0;
        endcase
    end

    // Index 0 is the lower half, index 1 the upper half
    for (genvar g = 0; g < 2; g++) begin : g_cnt
        evmon_counter #(
            .CNT_W    (CNT_W),
            .SEL_W    (SEL_W),
            .IS_UPPER (g == 1),
            .PARK_CODE(g == 1 ? PARK_UP : PARK_LO)
        ) u_cnt (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel          (g == 1 ? sel_up : sel_lo),
            .ctx_ok       (ctx_ok),
            .ev_cycle     (ev_cycle),
            .ev_instr     (ev_instr),
            .ev_cache_ref (ev_cache_ref),
            .ev_cache_miss(ev_cache_miss),
            .ev_marker_nop(ev_marker_nop),
            .wr_en        (cnt_we),
            .wr_val       (reg_wdata[g*CNT_W +: CNT_W]),
            .cnt_q        (cnt_val[g]),
            .wrap         (wrap[g])
        );
    end

    evmon_irq #(.N(2)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (wrap),
        .clr_we  (stat_we),
        .clr_mask(reg_wdata[1:0]),
        .irq_en  (irq_en),
        .flags_q (flags),
        .irq_o   (ovf_irq)
    );

    // Assemble the control word; gap bits between fields read zero
    always_comb begin
        ctrl_word = '0;
        ctrl_word[CB_IRQ_EN]         = irq_en;
        ctrl_word[CB_HYPER:CB_USER]  = ctx_en;
        ctrl_word[LO_LSB +: SEL_W]   = sel_lo;
        ctrl_word[UP_LSB +: SEL_W]   = sel_up;
    end

    // Read multiplexer
    always_comb begin
        case (reg_addr)
            ADR_CTRL: reg_rdata = DATA_W'(ctrl_word);
            ADR_CNT:  reg_rdata = {cnt_val[1], cnt_val[0]};
            ADR_STAT: reg_rdata = DATA_W'(flags);
            default:  reg_rdata = '0;
        endcase
    end

    // R9: lower counter leaving all-ones without a write must flag
    a_r9_lo_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val[0] == CNT_MAX && !cnt_we) |=> (cnt_val[0] == CNT_MAX || flags[0]));

    // R9: same for the upper counter
    a_r9_up_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val[1] == CNT_MAX && !cnt_we) |=> (cnt_val[1] == CNT_MAX || flags[1]));
endmodule

// File: tb/evmon_top_bench.sv
module evmon_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic [1:0]  priv_lvl;
    logic        ev_cycle, ev_instr, ev_cache_ref, ev_cache_miss, ev_marker_nop;
    logic        ovf_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference state
    logic [16:0] m_ctrl;
    logic [31:0] m_cnt [2];
    logic [1:0]  m_flg;

    always #10 clk = ~clk;

    evmon_top u_evmon_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .priv_lvl(priv_lvl),
        .ev_cycle(ev_cycle), .ev_instr(ev_instr), .ev_cache_ref(ev_cache_ref),
        .ev_cache_miss(ev_cache_miss), .ev_marker_nop(ev_marker_nop),
        .ovf_irq(ovf_irq)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {47'b0, m_ctrl};
            2'd1:    return {m_cnt[1], m_cnt[0]};
            2'd2:    return {62'b0, m_flg};
            default: return 64'b0;
        endcase
    endfunction

    // R5, R7: strobe chosen by a code on a given side
    function automatic logic pick(input int side, input logic [5:0] code, input logic [4:0] s);
        if (code == 6'h00) return s[0];
        if (code == 6'h01) return s[1];
        if (code == 6'h09) return side ? s[3] : s[2];
        if (code == (side ? 6'h1C : 6'h14)) return s[4];
        return 1'b0;
    endfunction

    // R6: privilege gate
    function automatic logic gate(input logic [1:0] p);
        case (p)
            2'd0: return m_ctrl[1];
            2'd1: return m_ctrl[2];
            2'd2: return m_ctrl[3];
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_update(input logic we, input logic [1:0] a, input logic [63:0] wd,
                                input logic [1:0] p, input logic [4:0] s);
        logic [1:0] wr;
        logic       g;
        g  = gate(p);
        wr = 2'b00;
        for (int k = 0; k < 2; k++) begin
            logic inc;
            inc = g & pick(k, k ? m_ctrl[16:11] : m_ctrl[9:4], s);
            if (we && a == 2'd1) m_cnt[k] = wd[k*32 +: 32];
            else if (inc) begin
                if (m_cnt[k] == 32'hFFFF_FFFF) wr[k] = 1'b1;
                m_cnt[k] = m_cnt[k] + 32'd1;
            end
        end
        m_flg = (m_flg & ~((we && a == 2'd2) ? wd[1:0] : 2'b00)) | wr;
        if (we && a == 2'd0) m_ctrl = {wd[16:11], 1'b0, wd[9:0]};
    endtask

    // One cycle: drive at falling edge, check pre-edge state, advance model
    task automatic step(input logic we, input logic [1:0] a, input logic [63:0] wd,
                        input logic [1:0] p, input logic [4:0] s);
        string tg;
        reg_we = we; reg_addr = a; reg_wdata = wd; priv_lvl = p;
        {ev_marker_nop, ev_cache_miss, ev_cache_ref, ev_instr, ev_cycle} = s;
        #1;
        tg = (a == 2'd1) ? "R2 counter read" : (a == 2'd2) ? "R9 status read" : "R4 control read";
        check(tg, reg_rdata, model_read(a));
        check("R11 irq", {63'b0, ovf_irq}, {63'b0, m_ctrl[0] & (|m_flg)});
        @(posedge clk);
        model_update(we, a, wd, p, s);
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [63:0] d);
        reg_we = 1'b0; reg_addr = a;
        {ev_marker_nop, ev_cache_miss, ev_cache_ref, ev_instr, ev_cycle} = 5'b0;
        #1 d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = 0; priv_lvl = 2'd3;
        {ev_marker_nop, ev_cache_miss, ev_cache_ref, ev_instr, ev_cycle} = 5'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = 17'h0E140; m_cnt[0] = 0; m_cnt[1] = 0; m_flg = 0;

        // R1: reset values
        peek(2'd0, d); check("R1 ctrl reset", d, 64'h0000_0000_0000_E140);
        peek(2'd1, d); check("R1 counters reset", d, 64'h0);
        peek(2'd2, d); check("R1 status reset", d, 64'h0);
        check("R1 irq reset", {63'b0, ovf_irq}, 64'h0);

        // R4: reserved bits read zero, address 3 ignored
        step(1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 5'b0);
        peek(2'd0, d); check("R4 ctrl mask", d, 64'h0000_0000_0001_FBFF);
        step(1, 2'd3, 64'h1234, 2'd3, 5'b0);
        peek(2'd3, d); check("R4 addr3 reads zero", d, 64'h0);
        peek(2'd0, d); check("R4 addr3 write ignored", d, 64'h0000_0000_0001_FBFF);

        // R2: packed layout
        step(1, 2'd1, 64'hAAAA_0001_5555_0002, 2'd3, 5'b0);
        peek(2'd1, d); check("R2 halves", d, 64'hAAAA_0001_5555_0002);

        // R5: lower code 9 -> refs, upper code 9 -> misses; user enabled
        step(1, 2'd0, (64'h09 << 11) | (64'h09 << 4) | 64'h2, 2'd3, 5'b0);
        step(0, 2'd0, 0, 2'd0, 5'b00100);
        peek(2'd1, d); check("R5 code9 lower counts ref", d, 64'hAAAA_0001_5555_0003);
        step(0, 2'd0, 0, 2'd0, 5'b01000);
        peek(2'd1, d); check("R5 code9 upper counts miss", d, 64'hAAAA_0002_5555_0003);

        // R6: supervisor level with only user enabled, and idle level
        step(0, 2'd0, 0, 2'd1, 5'b11111);
        step(0, 2'd0, 0, 2'd3, 5'b11111);
        peek(2'd1, d); check("R6 gated off", d, 64'hAAAA_0002_5555_0003);

        // R7: parked counters count only the marker strobe
        step(1, 2'd0, (64'h1C << 11) | (64'h14 << 4) | 64'h8, 2'd3, 5'b0);
        step(0, 2'd0, 0, 2'd2, 5'b01111);
        peek(2'd1, d); check("R7 parked ignores others", d, 64'hAAAA_0002_5555_0003);
        step(0, 2'd0, 0, 2'd2, 5'b10000);
        peek(2'd1, d); check("R7 parked counts marker", d, 64'hAAAA_0003_5555_0004);

        // R8 and R9: both on cycles, wrap lower from all-ones
        step(1, 2'd0, 64'h3, 2'd3, 5'b0);
        step(1, 2'd1, 64'h0000_0010_FFFF_FFFF, 2'd3, 5'b0);
        step(0, 2'd0, 0, 2'd0, 5'b00001);
        peek(2'd1, d); check("R8 one step / R9 wrap to zero", d, 64'h0000_0011_0000_0000);
        peek(2'd2, d); check("R9 lower flag", d, 64'h1);
        check("R11 irq high", {63'b0, ovf_irq}, 64'h1);

        // R3: write beats a same-cycle event at all-ones
        step(1, 2'd1, 64'hFFFF_FFFF_0000_0007, 2'd3, 5'b0);
        step(1, 2'd1, 64'hFFFF_FFFF_0000_0009, 2'd0, 5'b00001);
        peek(2'd1, d); check("R3 write wins", d, 64'hFFFF_FFFF_0000_0009);
        peek(2'd2, d); check("R3 no flag on write", d, 64'h1);

        // R10: clear with same-cycle upper wrap keeps the wrap
        step(1, 2'd2, 64'h3, 2'd0, 5'b00001);
        peek(2'd2, d); check("R10 set beats clear", d, 64'h2);
        step(1, 2'd2, 64'h0, 2'd3, 5'b0);
        peek(2'd2, d); check("R10 zero write keeps", d, 64'h2);
        step(1, 2'd2, 64'h2, 2'd3, 5'b0);
        peek(2'd2, d); check("R10 w1c", d, 64'h0);
        check("R11 irq low", {63'b0, ovf_irq}, 64'h0);

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [63:0] wd;
            logic [1:0]  a;
            logic        we;
            r  = $urandom_range(0, 99);
            we = 1'b0; a = 2'($urandom_range(0, 3)); wd = {$urandom, $urandom};
            if (r < 5) begin
                logic [5:0] cl, cu;
                int c;
                c  = $urandom_range(0, 4);
                cl = (c == 0) ? 6'h00 : (c == 1) ? 6'h01 : (c == 2) ? 6'h09 : (c == 3) ? 6'h14 : 6'($urandom);
                c  = $urandom_range(0, 4);
                cu = (c == 0) ? 6'h00 : (c == 1) ? 6'h01 : (c == 2) ? 6'h09 : (c == 3) ? 6'h1C : 6'($urandom);
                we = 1'b1; a = 2'd0;
                wd = (64'(cu) << 11) | (64'(cl) << 4) | 64'($urandom_range(0, 15)) | (wd & 64'hFFFF_FFFF_FFFE_0400);
            end else if (r < 9) begin
                we = 1'b1; a = 2'd1;
                wd = {32'hFFFF_FFF0 | 32'($urandom_range(0, 15)), 32'hFFFF_FFF0 | 32'($urandom_range(0, 15))};
            end else if (r < 12) begin
                we = 1'b1; a = 2'd2;
            end
            step(we, a, wd, 2'($urandom_range(0, 3)), 5'($urandom));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule